// File: doc/BRIEF.md
# Configurable-Width Ternary Match Array

This block is a small ternary content-addressable store. Every base location keeps a data word, a care mask and a valid flag. A search key is compared with every valid entry in parallel. The block then reports whether any entry matched and, if so, the lowest matching address. A runtime width field regroups the same physical locations into entries of one, two or four base words. A wide key is fed one base word per cycle, over as many cycles as an entry has words.

Eight global mask words sit beside the array, and each search selects one of them by a 3-bit index. A global mask bit of 0 removes that key bit from the compare. In the four-word mode, a pair of global masks is used. A simple programmed-I/O port writes and reads the data words, the care masks and the global masks. Data and mask writes can optionally be limited to the bits enabled by a chosen global mask.

Top module: `tern_match_array`

## Requirements
- R1: After reset, res_valid is 0, every location is invalid (so any search misses), and all eight global masks read back as all ones.
- R2: With cfg_wid = 0 (one word per entry), a one-beat search hits when some valid location equals the key on every compared bit. The reported index is that location's address.
- R3: A care-mask bit of 0 at a location makes that bit of the location a don't-care in the compare; a care bit of 1 makes the bit take part.
- R4: srch_gmr (3 bits) selects one of eight global masks. Key bits where the selected global mask is 0 take no part in any compare.
- R5: When several entries match, res_idx is the lowest matching base address.
- R6: With cfg_wid = 1, an entry is the even/odd pair 2i, 2i+1. Beat 0 of the key is compared with the even location and beat 1 with the odd location. res_idx is always the even address.
- R7: With cfg_wid = 2, an entry is four locations 4i..4i+3, compared against beats 0..3. Beats 0 and 1 use global mask g, and beats 2 and 3 use global mask g XOR 1, where g is the index sampled on beat 0. res_idx is a multiple of 4.
- R8: A data write with pio_use_gmr = 1 changes only the bits set in global mask pio_gmr_sel. All other bits keep their old value.
- R9: The result appears one cycle after the cycle that follows the last key beat: res_valid is high for exactly one cycle after the second rising edge from the edge that samples the last beat. On a miss, res_hit is 0 and res_idx is 0.
- R10: A write that shares its clock edge with the last key beat is not seen by that search. The next search does see it.
- R11: A read with pio_rd returns, one cycle later on pio_rdata, the word selected by pio_tgt: 0 = data, 1 = care mask, 2 = global mask (addressed by pio_addr[2:0]).
- R12: A location becomes valid only when its data word is written. A multi-word entry can match only when all of its locations are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wid | input | 2 | Entry width: 0 one word, 1 two words, 2 four words, 3 treated as one word |
| srch_valid | input | 1 | A key beat is present |
| srch_key | input | W | Key beat |
| srch_gmr | input | 3 | Global mask index, sampled on beat 0 |
| pio_wr | input | 1 | Write strobe |
| pio_rd | input | 1 | Read strobe |
| pio_tgt | input | 2 | Target: 0 data, 1 care mask, 2 global mask |
| pio_addr | input | AW | Location or global mask address |
| pio_wdata | input | W | Write data |
| pio_use_gmr | input | 1 | Limit the data or mask write to the bits of a global mask |
| pio_gmr_sel | input | 3 | Global mask used to limit the write |
| pio_rdata | output | W | Read data, one cycle after pio_rd |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | Some entry matched |
| res_idx | output | AW | Lowest matching base address |

## Verification
Two events can share a clock edge: a data write through the programmed-I/O port, and the last key beat of a search that would match the new contents. The bench drives both on the same edge and expects a miss from that search. It then repeats the search and expects a hit at the written address. This shows that the compare uses the array as it stood before the edge, and that the write still takes effect.

// File: rtl/tma_pkg.sv
package tma_pkg;
    // Entry width codes.
    typedef enum logic [1:0] {
        WID_X1 = 2'd0,
        WID_X2 = 2'd1,
        WID_X4 = 2'd2
    } wid_e;

    // Programmed-I/O targets.
    typedef enum logic [1:0] {
        TGT_DATA = 2'd0,
        TGT_MASK = 2'd1,
        TGT_GMR  = 2'd2
    } tgt_e;

    localparam int NGMR = 8;

    // Index of the last key beat for a width code (reserved code acts as one word).
    function automatic logic [1:0] last_beat(input logic [1:0] wid);
        case (wid)
            WID_X2:  last_beat = 2'd1;
            WID_X4:  last_beat = 2'd3;
            default: last_beat = 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/tma_store.sv
// tma_store: holds the data words, care masks, valid flags and global masks,
// and serves the programmed-I/O port.
// Assumes DEPTH >= 8 so that pio_addr[2:0] can address the global masks.
module tma_store
    import tma_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pio_wr,
    input  logic                      pio_rd,
    input  logic [1:0]                pio_tgt,
    input  logic [AW-1:0]             pio_addr,
    input  logic [W-1:0]              pio_wdata,
    input  logic                      pio_use_gmr,
    input  logic [2:0]                pio_gmr_sel,
    output logic [W-1:0]              pio_rdata,
    output logic [DEPTH-1:0][W-1:0]   data_o,
    output logic [DEPTH-1:0][W-1:0]   mask_o,
    output logic [DEPTH-1:0]          valid_o,
    output logic [NGMR-1:0][W-1:0]    gmr_o
);
    logic [DEPTH-1:0][W-1:0] data_q, mask_q;
    logic [DEPTH-1:0]        valid_q;
    logic [NGMR-1:0][W-1:0]  gmr_q;
    logic [W-1:0]            wen_bits;

    // Bit enables for a data or mask write.
    assign wen_bits = pio_use_gmr ? gmr_q[pio_gmr_sel] : {W{1'b1}};

    // Storage update for data and care masks (no reset on storage).
    always_ff @(posedge clk) begin
        if (pio_wr && pio_tgt == TGT_DATA)
            data_q[pio_addr] <= (data_q[pio_addr] & ~wen_bits) | (pio_wdata & wen_bits);
        if (pio_wr && pio_tgt == TGT_MASK)
            mask_q[pio_addr] <= (mask_q[pio_addr] & ~wen_bits) | (pio_wdata & wen_bits);
    end

    // Valid flags: cleared by reset, set by a data write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (pio_wr && pio_tgt == TGT_DATA)
            valid_q[pio_addr] <= 1'b1;
    end

    // Global masks: all ones after reset, plain word writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gmr_q <= {NGMR{{W{1'b1}}}};
        else if (pio_wr && pio_tgt == TGT_GMR)
            gmr_q[pio_addr[2:0]] <= pio_wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pio_rdata <= '0;
        else if (pio_rd) begin
            case (pio_tgt)
                TGT_DATA: pio_rdata <= data_q[pio_addr];
                TGT_MASK: pio_rdata <= mask_q[pio_addr];
                TGT_GMR:  pio_rdata <= gmr_q[pio_addr[2:0]];
                default:  pio_rdata <= '0;
            endcase
        end
    end

    assign data_o  = data_q;
    assign mask_o  = mask_q;
    assign valid_o = valid_q;
    assign gmr_o   = gmr_q;

    AST_VALID_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (pio_wr && pio_tgt == TGT_DATA) |=> valid_o[$past(pio_addr)]); // R12
endmodule

// File: rtl/tma_keyseq.sv
// tma_keyseq: collects key beats for the configured width, fires on the last
// beat, and supplies one key word and one global mask word for each beat.
// Assumes cfg_wid is held steady while a search is in flight.
module tma_keyseq
    import tma_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              cfg_wid,
    input  logic                    srch_valid,
    input  logic [W-1:0]            srch_key,
    input  logic [2:0]              srch_gmr,
    input  logic [NGMR-1:0][W-1:0]  gmr,
    output logic                    fire,
    output logic [1:0]              lb,
    output logic [3:0][W-1:0]       key_words,
    output logic [3:0][W-1:0]       gm_words
);
    logic [1:0]          cnt_q;
    logic [2:0]          gsel_q, gsel;
    logic [2:0][W-1:0]   kbuf_q;

    assign lb   = last_beat(cfg_wid);
    assign fire = srch_valid && (cnt_q == lb);
    assign gsel = (cnt_q == 2'd0) ? srch_gmr : gsel_q;

    // Beat counter and key buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            gsel_q <= '0;
            kbuf_q <= '0;
        end else if (srch_valid) begin
            if (cnt_q == 2'd0) gsel_q <= srch_gmr;
            if (fire) cnt_q <= '0;
            else begin
                kbuf_q[cnt_q] <= srch_key;
                cnt_q         <= cnt_q + 2'd1;
            end
        end
    end

    // Key word and global mask word for each beat position.
    always_comb begin
        for (int j = 0; j < 4; j++) begin
            if (2'(j) == lb || j == 3) key_words[j] = srch_key;
            else                       key_words[j] = kbuf_q[j];
            if (cfg_wid == WID_X4 && j >= 2) gm_words[j] = gmr[gsel ^ 3'd1];
            else                             gm_words[j] = gmr[gsel];
        end
    end

    AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lb); // R6
endmodule

// File: rtl/tma_match.sv
// tma_match: compares every location with its beat of the key, groups the
// locations into entries by width, registers the match vector, then
// priority-encodes it into a registered result.
// Assumes DEPTH is a multiple of 4.
module tma_match
    import tma_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                cfg_wid,
    input  logic [1:0]                lb,
    input  logic                      fire,
    input  logic [3:0][W-1:0]         key_words,
    input  logic [3:0][W-1:0]         gm_words,
    input  logic [DEPTH-1:0][W-1:0]   data,
    input  logic [DEPTH-1:0][W-1:0]   mask,
    input  logic [DEPTH-1:0]          valid,
    output logic                      res_valid,
    output logic                      res_hit,
    output logic [AW-1:0]             res_idx
);
    logic [DEPTH-1:0] loc_hit, e1, e2, e4, ent;
    logic [DEPTH-1:0] m_q;
    logic             m_v;
    logic [AW-1:0]    enc;

    for (genvar l = 0; l < DEPTH; l++) begin : g_loc
        logic [1:0] sel;
        // Beat position this location is compared against.
        assign sel = 2'(l % 4) & lb;
        assign loc_hit[l] = valid[l] &&
            ~|((data[l] ^ key_words[sel]) & mask[l] & gm_words[sel]);
        assign e1[l] = loc_hit[l];
        if (l % 2 == 0) begin : g_even
            assign e2[l] = loc_hit[l] & loc_hit[l+1];
        end else begin : g_odd
            assign e2[l] = 1'b0;
        end
        if (l % 4 == 0) begin : g_quad
            assign e4[l] = &loc_hit[l+3:l];
        end else begin : g_noquad
            assign e4[l] = 1'b0;
        end
    end

    // Entry match vector for the configured width.
    always_comb begin
        case (cfg_wid)
            WID_X2:  ent = e2;
            WID_X4:  ent = e4;
            default: ent = e1;
        endcase
    end

    // Stage 1: capture the match vector on the last key beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
            m_v <= 1'b0;
        end else begin
            m_v <= fire;
            if (fire) m_q <= ent;
        end
    end

    // Lowest set bit of the captured vector.
    always_comb begin
        enc = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (m_q[i]) enc = AW'(i);
    end

    // Stage 2: registered result, one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_idx   <= '0;
        end else begin
            res_valid <= m_v;
            res_hit   <= m_v && |m_q;
            res_idx   <= (m_v && |m_q) ? enc : '0;
        end
    end

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid); // R9
    AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(fire, 2)); // R9
    AST_IDX_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> ((res_idx[1:0] & lb) == 2'd0)); // R6
    AST_HIT_LOC_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> valid[res_idx]); // R12
endmodule

// File: rtl/tern_match_array.sv
// tern_match_array: ternary match array with runtime entry width, per-search
// global masks and a programmed-I/O port. Results come two edges after the
// edge that samples the last key beat.
// Assumes cfg_wid changes only while no search is in flight.
module tern_match_array
    import tma_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_wid,
    input  logic          srch_valid,
    input  logic [W-1:0]  srch_key,
    input  logic [2:0]    srch_gmr,
    input  logic          pio_wr,
    input  logic          pio_rd,
    input  logic [1:0]    pio_tgt,
    input  logic [AW-1:0] pio_addr,
    input  logic [W-1:0]  pio_wdata,
    input  logic          pio_use_gmr,
    input  logic [2:0]    pio_gmr_sel,
    output logic [W-1:0]  pio_rdata,
    output logic          res_valid,
    output logic          res_hit,
    output logic [AW-1:0] res_idx
);
    logic [DEPTH-1:0][W-1:0] data, mask;
    logic [DEPTH-1:0]        valid;
    logic [NGMR-1:0][W-1:0]  gmr;
    logic                    fire;
    logic [1:0]              lb;
    logic [3:0][W-1:0]       key_words, gm_words;

    tma_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .pio_wr(pio_wr), .pio_rd(pio_rd), .pio_tgt(pio_tgt),
        .pio_addr(pio_addr), .pio_wdata(pio_wdata),
        .pio_use_gmr(pio_use_gmr), .pio_gmr_sel(pio_gmr_sel),
        .pio_rdata(pio_rdata),
        .data_o(data), .mask_o(mask), .valid_o(valid), .gmr_o(gmr)
    );

    tma_keyseq #(.W(W)) u_keyseq (
        .clk(clk), .rst_n(rst_n), .cfg_wid(cfg_wid),
        .srch_valid(srch_valid), .srch_key(srch_key), .srch_gmr(srch_gmr),
        .gmr(gmr), .fire(fire), .lb(lb),
        .key_words(key_words), .gm_words(gm_words)
    );

    tma_match #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_match (
        .clk(clk), .rst_n(rst_n), .cfg_wid(cfg_wid), .lb(lb), .fire(fire),
        .key_words(key_words), .gm_words(gm_words),
        .data(data), .mask(mask), .valid(valid),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx)
    );
endmodule

// File: tb/tb_tern_match_array.sv
module tb_tern_match_array;
    localparam int W = 16;
    localparam int DEPTH = 16;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_wid = 2'd0;
    logic srch_valid = 1'b0;
    logic [W-1:0] srch_key = '0;
    logic [2:0] srch_gmr = '0;
    logic pio_wr = 1'b0, pio_rd = 1'b0, pio_use_gmr = 1'b0;
    logic [1:0] pio_tgt = '0;
    logic [AW-1:0] pio_addr = '0;
    logic [W-1:0] pio_wdata = '0;
    logic [2:0] pio_gmr_sel = '0;
    logic [W-1:0] pio_rdata;
    logic res_valid, res_hit;
    logic [AW-1:0] res_idx;

    int tests = 0;
    int fails = 0;

    tern_match_array #(.W(W), .DEPTH(DEPTH), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wid(cfg_wid),
        .srch_valid(srch_valid), .srch_key(srch_key), .srch_gmr(srch_gmr),
        .pio_wr(pio_wr), .pio_rd(pio_rd), .pio_tgt(pio_tgt),
        .pio_addr(pio_addr), .pio_wdata(pio_wdata),
        .pio_use_gmr(pio_use_gmr), .pio_gmr_sel(pio_gmr_sel),
        .pio_rdata(pio_rdata),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic pio_write(input logic [1:0] tgt, input int addr, input logic [W-1:0] wd,
                             input logic use_g, input logic [2:0] gs);
        @(negedge clk);
        pio_wr = 1'b1; pio_tgt = tgt; pio_addr = AW'(addr); pio_wdata = wd;
        pio_use_gmr = use_g; pio_gmr_sel = gs;
        @(negedge clk);
        pio_wr = 1'b0; pio_use_gmr = 1'b0;
    endtask

    task automatic pio_read(input logic [1:0] tgt, input int addr, output logic [W-1:0] rd);
        @(negedge clk);
        pio_rd = 1'b1; pio_tgt = tgt; pio_addr = AW'(addr);
        @(negedge clk);
        pio_rd = 1'b0;
        rd = pio_rdata;
    endtask

    // Drives n beats, then checks the one-cycle result strobe timing (R9).
    task automatic search(input logic [W-1:0] k0, input logic [W-1:0] k1,
                          input logic [W-1:0] k2, input logic [W-1:0] k3,
                          input int n, input logic [2:0] g,
                          output logic hit, output logic [AW-1:0] idx);
        logic [3:0][W-1:0] ks;
        ks = {k3, k2, k1, k0};
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            srch_valid = 1'b1; srch_key = ks[i]; srch_gmr = g;
        end
        @(negedge clk);
        srch_valid = 1'b0;
        check(res_valid == 1'b0, "R9 early strobe", 32'(res_valid), 0);
        @(negedge clk);
        check(res_valid == 1'b1, "R9 strobe", 32'(res_valid), 1);
        hit = res_hit; idx = res_idx;
        if (!hit) check(idx == 0, "R9 miss index", 32'(idx), 0);
        @(negedge clk);
        check(res_valid == 1'b0, "R9 strobe width", 32'(res_valid), 0);
    endtask

    task automatic t_reset();
        logic h; logic [AW-1:0] ix; logic [W-1:0] rd;
        check(res_valid == 1'b0, "R1 res_valid", 32'(res_valid), 0);
        pio_read(2'd2, 7, rd);
        check(rd == 16'hFFFF, "R1 gmr reset", 32'(rd), 32'hFFFF);
        search(16'h0000, 0, 0, 0, 1, 3'd0, h, ix);
        check(h == 1'b0, "R1 no valid entries", 32'(h), 0);
    endtask

    task automatic t_single();
        logic h; logic [AW-1:0] ix;
        cfg_wid = 2'd0;
        pio_write(2'd1, 5, 16'hFFFF, 0, 0);
        pio_write(2'd1, 9, 16'hFFFF, 0, 0);
        pio_write(2'd0, 5, 16'h1234, 0, 0);
        pio_write(2'd0, 9, 16'h1234, 0, 0);
        search(16'h1234, 0, 0, 0, 1, 3'd0, h, ix);
        check(h == 1'b1, "R2 single hit", 32'(h), 1);
        check(ix == 5, "R5 lowest index", 32'(ix), 5);
        search(16'h1235, 0, 0, 0, 1, 3'd0, h, ix);
        check(h == 1'b0, "R2 single miss", 32'(h), 0);
    endtask

    task automatic t_entry_mask();
        logic h; logic [AW-1:0] ix;
        pio_write(2'd1, 3, 16'hFF00, 0, 0);
        pio_write(2'd0, 3, 16'hAB00, 0, 0);
        search(16'hABCD, 0, 0, 0, 1, 3'd0, h, ix);
        check(h == 1'b1 && ix == 3, "R3 care mask don't-care", 32'({h, ix}), 32'({1'b1, 4'd3}));
    endtask

    task automatic t_gmr();
        logic h; logic [AW-1:0] ix;
        pio_write(2'd2, 2, 16'h0FFF, 0, 0);
        search(16'h7234, 0, 0, 0, 1, 3'd2, h, ix);
        check(h == 1'b1 && ix == 5, "R4 global mask 2", 32'({h, ix}), 32'({1'b1, 4'd5}));
        search(16'h7234, 0, 0, 0, 1, 3'd0, h, ix);
        check(h == 1'b0, "R4 global mask 0", 32'(h), 0);
    endtask

    task automatic t_masked_write();
        logic [W-1:0] rd;
        pio_write(2'd0, 5, 16'hFFFF, 1, 3'd2);
        pio_read(2'd0, 5, rd);
        check(rd == 16'h1FFF, "R8 masked write", 32'(rd), 32'h1FFF);
        pio_read(2'd1, 3, rd);
        check(rd == 16'hFF00, "R11 read mask", 32'(rd), 32'hFF00);
        pio_read(2'd2, 2, rd);
        check(rd == 16'h0FFF, "R11 read gmr", 32'(rd), 32'h0FFF);
    endtask

    task automatic t_double();
        logic h; logic [AW-1:0] ix;
        cfg_wid = 2'd1;
        for (int a = 6; a <= 11; a++) pio_write(2'd1, a, 16'hFFFF, 0, 0);
        pio_write(2'd0, 6, 16'h1111, 0, 0);
        pio_write(2'd0, 7, 16'h2222, 0, 0);
        pio_write(2'd0, 8, 16'h1111, 0, 0);
        pio_write(2'd0, 9, 16'h2222, 0, 0);
        pio_write(2'd0, 10, 16'h3333, 0, 0);
        search(16'h1111, 16'h2222, 0, 0, 2, 3'd0, h, ix);
        check(h == 1'b1 && ix == 6, "R6 pair hit even index", 32'({h, ix}), 32'({1'b1, 4'd6}));
        search(16'h2222, 16'h1111, 0, 0, 2, 3'd0, h, ix);
        check(h == 1'b0, "R6 swapped halves miss", 32'(h), 0);
        search(16'h3333, 16'h0000, 0, 0, 2, 3'd0, h, ix);
        check(h == 1'b0, "R12 odd half invalid", 32'(h), 0);
    endtask

    task automatic t_quad();
        logic h; logic [AW-1:0] ix;
        cfg_wid = 2'd2;
        for (int a = 12; a <= 15; a++) pio_write(2'd1, a, 16'hFFFF, 0, 0);
        pio_write(2'd0, 12, 16'hA0A0, 0, 0);
        pio_write(2'd0, 13, 16'hB0B0, 0, 0);
        pio_write(2'd0, 14, 16'hC0C0, 0, 0);
        pio_write(2'd0, 15, 16'hD0D0, 0, 0);
        pio_write(2'd2, 5, 16'h00FF, 0, 0);
        search(16'hA0A0, 16'hB0B0, 16'h77C0, 16'h55D0, 4, 3'd4, h, ix);
        check(h == 1'b1 && ix == 12, "R7 quad hit with mask pair", 32'({h, ix}), 32'({1'b1, 4'd12}));
        search(16'hA0A0, 16'hB0B0, 16'h77C0, 16'h55D0, 4, 3'd5, h, ix);
        check(h == 1'b0, "R7 swapped mask pair miss", 32'(h), 0);
    endtask

    task automatic t_collision();
        logic h; logic [AW-1:0] ix;
        cfg_wid = 2'd0;
        @(negedge clk);
        srch_valid = 1'b1; srch_key = 16'h4242; srch_gmr = 3'd0;
        pio_wr = 1'b1; pio_tgt = 2'd0; pio_addr = 4'd14; pio_wdata = 16'h4242;
        @(negedge clk);
        srch_valid = 1'b0; pio_wr = 1'b0;
        @(negedge clk);
        check(res_valid == 1'b1 && res_hit == 1'b0, "R10 same-edge write unseen",
              32'({res_valid, res_hit}), 32'h2);
        search(16'h4242, 0, 0, 0, 1, 3'd0, h, ix);
        check(h == 1'b1 && ix == 14, "R10 write seen next search", 32'({h, ix}), 32'({1'b1, 4'd14}));
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_entry_mask();
        t_gmr();
        t_masked_write();
        t_double();
        t_quad();
        t_collision();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule